// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-mapped master for the two-wire PHY management bus. It runs both the older short-address frame format (Clause 22) and the extended format (Clause 45). Software programs a configuration word, loads a data word when one is needed, and then writes a command word. The command names an operation, a PHY address and a register or device address. Writing the command starts a serial frame on MDC/MDIO. A pending flag shows progress. For reads, a valid flag shows whether the returned data can be trusted.

A single 2-bit operation field is read in two ways, chosen by the clause-mode bit. Write and address frames take their payload from the write-data word and report progress through that word's pending flag. Reads report progress through their own pending flag and leave a 16-bit result with a valid flag. An extended access takes two commands: an address frame that carries the 16-bit register number, then a data frame that carries the device address. MDC is derived from the system clock by a programmable divider. The data line is driven by the master, or released to a pull-up for the PHY's turnaround and read data.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset MDC is low, MDIO is not driven, and the write-data, read-data and enable words read back as zero.
- R2: CSR byte offsets: command 0x00 (register/device address bits 4:0, PHY address bits 12:8, operation bits 17:16); write data 0x08 (data 15:0, pending bit 31); read data 0x10 (data 15:0, valid bit 30, pending bit 31); configuration 0x18 (bit 0 = Clause 45 mode, bit 1 = preamble on, bits 15:8 = MDC half-period minus one); enable 0x20 (bit 0). Any other offset reads as zero.
- R3: In Clause 22 mode a frame starts with 01. Operation bit 0 selects the bus opcode: 0 gives a write (bus opcode 01) and 1 gives a read (bus opcode 10). Operation bit 1 is ignored. The frame then carries the PHY address, then the register address, each MSB first.
- R4: In Clause 45 mode a frame starts with 00 and the bus opcode equals the operation value: 0 is an address frame, 1 a write, 3 a read, and 2 a read with post-increment. Operation bit 1 set means a read.
- R5: Write and address frames drive the turnaround as 1 then 0, then the 16 bits of the write-data word, MSB first. The write-data pending bit is set when the frame starts and clears when it ends.
- R6: Read frames release MDIO from the first turnaround bit to the end of the frame. Data bits are sampled on MDC rising edges. The read pending bit stays set during the frame; at its end the 16 sampled bits appear in the read-data word with valid set.
- R7: If MDIO is not low during the second turnaround bit of a read, the valid bit stays clear when the frame ends.
- R8: With preamble on, 32 one bits come before the start bits; with it off, the frame begins directly with the start bits.
- R9: While a frame runs, each MDC half-period lasts (divider field + 1) clock cycles. MDC is low when idle, and the master changes MDIO only when MDC falls.
- R10: A command written while a frame is pending is ignored and does not change the frame in progress.
- R11: While enable bit 0 is clear, commands are ignored. Clearing it during a frame stops the frame: pending bits clear, MDC stays low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Sampled data line |

## Verification
The hardest situation to reach from the ports is a read whose second turnaround bit is not driven low, together with a command written while a frame is already in flight. The bench's PHY responder counts MDC rising edges from the expected frame at the head of the scoreboard queue. It can be told to leave the second turnaround bit released, so the pull-up produces a bad turnaround. For the ignored-command case, the driver writes a second command with a different PHY address two cycles after the first one launches. The captured frame and the number of MDC edges afterwards then show that the second command left no trace.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int TOT_BITS   = PRE_BITS + FRAME_BITS;
  localparam int CNT_W      = $clog2(TOT_BITS);
  localparam int WORD_W     = 16;
  localparam int TA_POS     = 14;
  localparam int DATA_POS   = 16;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_WDAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RDAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_EN   = 6'h20;

  localparam int CMD_REG_LSB = 0;
  localparam int CMD_PHY_LSB = 8;
  localparam int CMD_OP_LSB  = 16;
  localparam int PEND_BIT    = 31;
  localparam int VALID_BIT   = 30;
  localparam int CFG_C45_BIT = 0;
  localparam int CFG_PRE_BIT = 1;
  localparam int CFG_DIV_LSB = 8;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] regad;
  } cmd_t;

  function automatic logic [1:0] bus_op(input logic c45, input logic [1:0] op);
    if (c45) return op;
    return op[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic op_is_read(input logic c45, input logic [1:0] op);
    return c45 ? op[1] : op[0];
  endfunction
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap      = run && (cnt_q >= half);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R9
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                with_pre,
  input  logic                rd_op,
  input  logic [TOT_BITS-1:0] frame_bits,
  input  logic                rise_tick,
  input  logic                fall_tick,
  input  logic                mdio_in,
  output logic                busy,
  output logic                mdio_out,
  output logic                mdio_oe,
  output logic                done,
  output logic [WORD_W-1:0]   rd_word,
  output logic                rd_ok
);
  logic                busy_q, busy_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_nx, fpos;
  logic [TOT_BITS-1:0] sh_q, sh_d, sh_load;
  logic                rdop_q, rdop_d;
  logic                out_q, out_d;
  logic                oe_q, oe_d;
  logic [WORD_W-1:0]   rx_q, rx_d;
  logic                taerr_q, taerr_d;
  logic                last_bit, in_frame;

  assign fpos     = cnt_q - CNT_W'(PRE_BITS);
  assign cnt_nx   = cnt_q + 1'b1;
  assign last_bit = (cnt_q == CNT_W'(TOT_BITS - 1));
  assign in_frame = (cnt_q >= CNT_W'(PRE_BITS));
  assign sh_load  = with_pre ? frame_bits : (frame_bits << PRE_BITS);

  assign busy     = busy_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
  assign done     = busy_q && fall_tick && last_bit && !abort;
  assign rd_word  = rx_q;
  assign rd_ok    = !taerr_q;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rdop_d  = rdop_q;
    out_d   = out_q;
    oe_d    = oe_q;
    rx_d    = rx_q;
    taerr_d = taerr_q;
    if (abort) begin
      busy_d = 1'b0;
      oe_d   = 1'b0;
      out_d  = 1'b1;
      cnt_d  = '0;
    end else if (start && !busy_q) begin
      busy_d  = 1'b1;
      cnt_d   = with_pre ? '0 : CNT_W'(PRE_BITS);
      sh_d    = sh_load;
      out_d   = sh_load[TOT_BITS-1];
      oe_d    = 1'b1;
      rdop_d  = rd_op;
      taerr_d = 1'b0;
      rx_d    = '0;
    end else if (busy_q) begin
      if (rise_tick && rdop_q && in_frame) begin
        if (fpos == CNT_W'(TA_POS + 1)) begin
          taerr_d = mdio_in;
        end else if (fpos >= CNT_W'(DATA_POS)) begin
          rx_d = {rx_q[WORD_W-2:0], mdio_in};
        end
      end
      if (fall_tick) begin
        if (last_bit) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          out_d  = 1'b1;
        end else begin
          cnt_d = cnt_nx;
          sh_d  = sh_q << 1;
          out_d = sh_q[TOT_BITS-2];
          oe_d  = !(rdop_q && (cnt_nx >= CNT_W'(PRE_BITS + TA_POS)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      rdop_q  <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
      rx_q    <= '0;
      taerr_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rdop_q  <= rdop_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      rx_q    <= rx_d;
      taerr_q <= taerr_d;
    end
  end

  // R9
  mdio_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_tick && !start && !abort) |=> $stable(out_q));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && !oe_q));
endmodule

// File: rtl/mgmt_csr.sv
module mgmt_csr
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [ADDR_W-1:0]   csr_addr,
  input  logic [DATA_W-1:0]   csr_wdata,
  output logic [DATA_W-1:0]   csr_rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [WORD_W-1:0]   rd_word,
  input  logic                rd_ok,
  output logic                start,
  output logic                abort,
  output logic                with_pre,
  output logic                rd_op,
  output logic [TOT_BITS-1:0] frame_bits,
  output logic [DIV_W-1:0]    half
);
  cmd_t              cmd_q, cmd_d, cmd_in;
  logic [WORD_W-1:0] wdat_q, wdat_d, rdat_q, rdat_d;
  logic              wpend_q, wpend_d, rpend_q, rpend_d, rval_q, rval_d;
  logic              c45_q, c45_d, pre_q, pre_d, en_q, en_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic              wr_cmd, wr_wdat, wr_cfg, wr_en;
  logic [1:0]        ta_bits;
  logic [WORD_W-1:0] payload;
  logic              unused_hi;

  assign unused_hi = ^csr_wdata[DATA_W-1:CMD_OP_LSB+2];

  assign cmd_in.op    = csr_wdata[CMD_OP_LSB +: 2];
  assign cmd_in.phy   = csr_wdata[CMD_PHY_LSB +: 5];
  assign cmd_in.regad = csr_wdata[CMD_REG_LSB +: 5];

  assign wr_cmd  = csr_wr && (csr_addr == OFS_CMD);
  assign wr_wdat = csr_wr && (csr_addr == OFS_WDAT);
  assign wr_cfg  = csr_wr && (csr_addr == OFS_CFG);
  assign wr_en   = csr_wr && (csr_addr == OFS_EN);

  assign start    = wr_cmd && en_q && !busy;
  assign abort    = !en_q;
  assign with_pre = pre_q;
  assign half     = half_q;
  assign rd_op    = op_is_read(c45_q, cmd_in.op);
  assign ta_bits  = rd_op ? 2'b11 : 2'b10;
  assign payload  = rd_op ? {WORD_W{1'b1}} : wdat_q;
  assign frame_bits = {{PRE_BITS{1'b1}}, (c45_q ? 2'b00 : 2'b01),
                       bus_op(c45_q, cmd_in.op), cmd_in.phy, cmd_in.regad,
                       ta_bits, payload};

  always_comb begin
    cmd_d   = cmd_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    wpend_d = wpend_q;
    rpend_d = rpend_q;
    rval_d  = rval_q;
    c45_d   = c45_q;
    pre_d   = pre_q;
    half_d  = half_q;
    en_d    = en_q;
    if (wr_wdat) wdat_d = csr_wdata[WORD_W-1:0];
    if (wr_cfg) begin
      c45_d  = csr_wdata[CFG_C45_BIT];
      pre_d  = csr_wdata[CFG_PRE_BIT];
      half_d = csr_wdata[CFG_DIV_LSB +: DIV_W];
    end
    if (wr_en) en_d = csr_wdata[0];
    if (start) begin
      cmd_d = cmd_in;
      if (rd_op) begin
        rpend_d = 1'b1;
        rval_d  = 1'b0;
      end else begin
        wpend_d = 1'b1;
      end
    end
    if (done) begin
      wpend_d = 1'b0;
      if (rpend_q) begin
        rpend_d = 1'b0;
        rdat_d  = rd_word;
        rval_d  = rd_ok;
      end
    end
    if (abort) begin
      wpend_d = 1'b0;
      rpend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      wpend_q <= 1'b0;
      rpend_q <= 1'b0;
      rval_q  <= 1'b0;
      c45_q   <= 1'b0;
      pre_q   <= 1'b0;
      half_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
      wpend_q <= wpend_d;
      rpend_q <= rpend_d;
      rval_q  <= rval_d;
      c45_q   <= c45_d;
      pre_q   <= pre_d;
      half_q  <= half_d;
      en_q    <= en_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      OFS_CMD: begin
        csr_rdata[CMD_OP_LSB +: 2]  = cmd_q.op;
        csr_rdata[CMD_PHY_LSB +: 5] = cmd_q.phy;
        csr_rdata[CMD_REG_LSB +: 5] = cmd_q.regad;
      end
      OFS_WDAT: begin
        csr_rdata[WORD_W-1:0] = wdat_q;
        csr_rdata[PEND_BIT]   = wpend_q;
      end
      OFS_RDAT: begin
        csr_rdata[WORD_W-1:0] = rdat_q;
        csr_rdata[VALID_BIT]  = rval_q;
        csr_rdata[PEND_BIT]   = rpend_q;
      end
      OFS_CFG: begin
        csr_rdata[CFG_C45_BIT]           = c45_q;
        csr_rdata[CFG_PRE_BIT]           = pre_q;
        csr_rdata[CFG_DIV_LSB +: DIV_W]  = half_q;
      end
      OFS_EN:  csr_rdata[0] = en_q;
      default: csr_rdata = '0;
    endcase
  end

  // R10
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wpend_q && rpend_q));

  // R6
  val_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rval_q) |-> $fell(rpend_q));

  // R5
  wpend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wpend_q) |-> ($past(done) || $past(abort)));
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic                busy, done, start, abort, with_pre, rd_op, rd_ok;
  logic                rise_tick, fall_tick;
  logic [WORD_W-1:0]   rd_word;
  logic [TOT_BITS-1:0] frame_bits;
  logic [DIV_W-1:0]    half;

  mgmt_csr #(.DIV_W(DIV_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .busy       (busy),
    .done       (done),
    .rd_word    (rd_word),
    .rd_ok      (rd_ok),
    .start      (start),
    .abort      (abort),
    .with_pre   (with_pre),
    .rd_op      (rd_op),
    .frame_bits (frame_bits),
    .half       (half)
  );

  mgmt_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .half      (half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .with_pre   (with_pre),
    .rd_op      (rd_op),
    .frame_bits (frame_bits),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_in    (mdio_in),
    .busy       (busy),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .done       (done),
    .rd_word    (rd_word),
    .rd_ok      (rd_ok)
  );
endmodule

// File: tb/test_mgmt_serial_master.sv
module test_mgmt_serial_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CMD = 6'h00, A_WDAT = 6'h08, A_RDAT = 6'h10,
                         A_CFG = 6'h18, A_EN = 6'h20;

  typedef struct {
    int          len;
    logic [63:0] bits;
    bit          is_read;
    logic [15:0] rdata;
    bit          ta_bad;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        phy_oe, phy_bit;
  logic        mdio_line;
  logic [63:0] got;
  int          nbits;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [7:0]  cur_half = 8'd1;
  exp_t        exp_q[$];

  assign mdio_line = mdio_oe ? mdio_out : (phy_oe ? phy_bit : 1'b1);

  mgmt_serial_master i_mgmt_serial_master (
    .clk(clk), .rst_n(rst_n), .csr_wr(wr), .csr_addr(addr),
    .csr_wdata(wdata), .csr_rdata(rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_line));

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: collects every bit seen on a rising MDC edge
  always @(posedge mdc) begin
    got   = {got[62:0], mdio_line};
    nbits = nbits + 1;
  end

  // PHY responder: drives turnaround and read data after MDC falls
  always @(negedge mdc) begin
    int k;
    phy_oe = 1'b0;
    if (exp_q.size() > 0 && exp_q[0].is_read) begin
      k = nbits - (exp_q[0].len - 32);
      if (k == 15) begin
        phy_oe  = !exp_q[0].ta_bad;
        phy_bit = 1'b0;
      end else if (k >= 16 && k <= 31) begin
        phy_oe  = 1'b1;
        phy_bit = exp_q[0].rdata[31-k];
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic csr_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic csr_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic measure_mdc(input int exp_cycles, input string req);
    realtime t0, t1;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check((t1 - t0) == exp_cycles * CLK_PERIOD, req,
          64'((t1 - t0) / CLK_PERIOD), 64'(exp_cycles));
  endtask

  // driver: push expected frame, launch, then score when pending drops
  task automatic run_op(input bit c45, input bit pre, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] dat, input bit ta_bad,
                        input bit intrude, input string req);
    exp_t        e;
    logic [31:0] f, v;
    logic [1:0]  st, bop;
    bit          rd;
    int          after;
    rd  = c45 ? op[1] : op[0];
    st  = c45 ? 2'b00 : 2'b01;
    bop = c45 ? op : (op[0] ? 2'b10 : 2'b01);
    f   = rd ? {st, bop, phy, rg, 1'b1, ta_bad, dat}
             : {st, bop, phy, rg, 2'b10, dat};
    e.len = pre ? 64 : 32;
    e.bits = pre ? {32'hFFFF_FFFF, f} : {32'h0, f};
    e.is_read = rd; e.rdata = dat; e.ta_bad = ta_bad;
    csr_write(A_CFG, {16'h0, cur_half, 6'h0, pre, c45});
    if (!rd) csr_write(A_WDAT, {16'h0, dat});
    got = '0; nbits = 0;
    exp_q.push_back(e);
    csr_write(A_CMD, {14'h0, op, 3'h0, phy, 3'h0, rg});
    csr_read(rd ? A_RDAT : A_WDAT, v);
    check(v[31] == 1'b1, rd ? {req, " R6 pending"} : {req, " R5 pending"},
          64'(v[31]), 64'd1);
    if (intrude) csr_write(A_CMD, {14'h0, op, 3'h0, ~phy, 3'h0, ~rg});
    do csr_read(rd ? A_RDAT : A_WDAT, v); while (v[31]);
    e = exp_q.pop_front();
    check(nbits == e.len, {req, " bit count"}, 64'(nbits), 64'(e.len));
    if (e.len == 64)
      check(got == e.bits, {req, " frame"}, got, e.bits);
    else
      check(got[31:0] == e.bits[31:0], {req, " frame"},
            64'(got[31:0]), 64'(e.bits[31:0]));
    if (rd) begin
      check(v[30] == !ta_bad, ta_bad ? {req, " R7 valid"} : {req, " R6 valid"},
            64'(v[30]), 64'(!ta_bad));
      if (!ta_bad)
        check(v[15:0] == dat, {req, " R6 data"}, 64'(v[15:0]), 64'(dat));
    end
    check(mdio_oe == 1'b0 && mdc == 1'b0, {req, " R9 idle"},
          64'({mdc, mdio_oe}), 64'h0);
    if (intrude) begin
      after = nbits;
      repeat (400) @(negedge clk);
      check(nbits == after, "R10 no second frame", 64'(nbits), 64'(after));
      csr_read(A_CMD, v);
      check(v == {14'h0, op, 3'h0, phy, 3'h0, rg}, "R10 R2 command readback",
            64'(v), 64'({14'h0, op, 3'h0, phy, 3'h0, rg}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          snap;
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    phy_oe = 1'b0; phy_bit = 1'b1; got = '0; nbits = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'd0);
    check(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'd0);
    csr_read(A_WDAT, v); check(v == 32'h0, "R1 wdat", 64'(v), 64'd0);
    csr_read(A_RDAT, v); check(v == 32'h0, "R1 rdat", 64'(v), 64'd0);
    csr_read(A_EN, v);   check(v == 32'h0, "R1 enable", 64'(v), 64'd0);

    // R11 commands ignored while disabled
    csr_write(A_CMD, {14'h0, 2'b00, 3'h0, 5'h3, 3'h0, 5'h4});
    repeat (200) @(negedge clk);
    check(nbits == 0, "R11 disabled no frame", 64'(nbits), 64'd0);
    csr_read(A_WDAT, v); check(v[31] == 1'b0, "R11 disabled pending", 64'(v[31]), 64'd0);

    // R2 register map
    csr_write(A_EN, 32'h1);
    csr_write(A_CFG, 32'h0000_2A03);
    csr_read(A_CFG, v); check(v == 32'h0000_2A03, "R2 cfg readback", 64'(v), 64'h2A03);
    csr_read(6'h28, v); check(v == 32'h0, "R2 unused offset", 64'(v), 64'd0);

    // R3 R5 R8 R9 Clause 22 write with preamble, period 4
    cur_half = 8'd1;
    fork
      run_op(1'b0, 1'b1, 2'b00, 5'h11, 5'h05, 16'hBEEF, 1'b0, 1'b0, "R3 R5 R8 c22 write");
      measure_mdc(4, "R9 period half=1");
    join
    // R3 R6 Clause 22 read with preamble
    run_op(1'b0, 1'b1, 2'b01, 5'h02, 5'h1F, 16'hA5C3, 1'b0, 1'b0, "R3 R6 c22 read");
    // R3 R8 read via opcode 3 (bit 1 ignored), no preamble
    run_op(1'b0, 1'b0, 2'b11, 5'h1E, 5'h00, 16'h0F0F, 1'b0, 1'b0, "R3 R8 c22 read op3");
    // R4 R5 Clause 45 address frame
    run_op(1'b1, 1'b1, 2'b00, 5'h04, 5'h07, 16'h1234, 1'b0, 1'b0, "R4 R5 c45 address");
    // R4 R9 Clause 45 write, no preamble, period 8
    cur_half = 8'd3;
    fork
      run_op(1'b1, 1'b0, 2'b01, 5'h04, 5'h07, 16'h8001, 1'b0, 1'b0, "R4 c45 write");
      measure_mdc(8, "R9 period half=3");
    join
    cur_half = 8'd1;
    // R4 R6 Clause 45 read and read-increment
    run_op(1'b1, 1'b0, 2'b11, 5'h09, 5'h01, 16'h5A5A, 1'b0, 1'b0, "R4 R6 c45 read");
    run_op(1'b1, 1'b1, 2'b10, 5'h09, 5'h01, 16'hC001, 1'b0, 1'b0, "R4 c45 read incr");
    // R7 bad turnaround
    run_op(1'b0, 1'b0, 2'b01, 5'h06, 5'h02, 16'h7777, 1'b1, 1'b0, "R7 bad turnaround");
    // R6 good read after a bad one restores valid
    run_op(1'b0, 1'b0, 2'b01, 5'h06, 5'h02, 16'h0001, 1'b0, 1'b0, "R6 valid restore");
    // R10 command while pending ignored
    run_op(1'b0, 1'b1, 2'b00, 5'h0A, 5'h0C, 16'h4321, 1'b0, 1'b1, "R10 busy write");

    // R11 abort mid-frame
    csr_write(A_CFG, 32'h0000_0102);
    csr_write(A_CMD, {14'h0, 2'b00, 3'h0, 5'h01, 3'h0, 5'h01});
    repeat (60) @(negedge clk);
    csr_write(A_EN, 32'h0);
    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R11 abort idle", 64'({mdc, mdio_oe}), 64'd0);
    csr_read(A_WDAT, v); check(v[31] == 1'b0, "R11 abort pending", 64'(v[31]), 64'd0);
    snap = nbits;
    repeat (100) @(negedge clk);
    check(nbits == snap, "R11 abort no edges", 64'(nbits), 64'(snap));
    csr_write(A_EN, 32'h1);
    run_op(1'b0, 1'b0, 2'b01, 5'h12, 5'h13, 16'h9ABC, 1'b0, 1'b0, "R11 after re-enable");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule